// File: doc/BRIEF.md
# Working Register File with Word Pointers

This block is the general-purpose register store of a small 8-bit processor core. It holds thirty-two byte registers, each cleared by a synchronous reset. Two independent combinational byte read ports supply operands. A single clocked write port stores either one byte or an aligned 16-bit register pair. A third combinational path returns an aligned pair as a 16-bit word, so all four operand/result combinations can be served in one cycle:

- byte in, byte out
- two bytes in, byte out
- two bytes in, word out
- word in, word out

The six highest registers also act as three 16-bit indirect-address pointers. These are named X, Y and Z, and each keeps its low byte in the lower-numbered register. Their current words are always visible on an output bus. A separate pointer-load port can replace any one of them as a whole word.

The same registers also sit at the lowest addresses of the data address space. A byte-wide data-bus port can read them and write them there. Where several write sources reach the same byte in one cycle, a fixed priority decides which source wins.

Top module: `gpr_file`

## Requirements
- R1: When `rst` is high at a rising clock edge, all 32 registers become 0x00.
- R2: With `wrEn`=1 and `wrWide`=0, `wrData[7:0]` is stored into register `wrAddr` at the rising edge.
- R3: `rdDataA` and `rdDataB` are combinational reads of registers `rdAddrA` and `rdAddrB`.
- R4: With `wrEn`=1, `wrWide`=1 and an even `wrAddr`=2k, register 2k takes `wrData[7:0]` and register 2k+1 takes `wrData[15:8]` at the rising edge.
- R5: With `wrEn`=1, `wrWide`=1 and an odd `wrAddr`, `wrErr` is 1 in that cycle and no register changes through the general write port.
- R6: For an even `pairRdAddr`=2k, `pairRdData` is {R[2k+1], R[2k]} and `pairRdErr` is 0. For an odd address, `pairRdErr` is 1 and `pairRdData` is 0.
- R7: A read of a register that is being written in the same cycle returns the old value; the new value is read from the cycle after the edge.
- R8: `ptrWords[16*j+15:16*j]` equals {R[27+2j], R[26+2j]}, where j=0 is X, j=1 is Y and j=2 is Z.
- R9: With `ptrWrEn`=1, `ptrSel` 0, 1 or 2 loads `ptrWrData` into X, Y or Z (low byte to the even register). A `ptrSel` of 3 changes nothing.
- R10: Priority is resolved byte by byte. The general write port beats the data-bus write, and the data-bus write beats the pointer load. A byte not claimed by a higher source still takes the lower source's data.
- R11: When `memAddr` < 32, `memHit`=1 and `memRdData` = R[`memAddr`]. Otherwise `memHit`=0 and `memRdData`=0x00.
- R12: With `memWrEn`=1 and `memAddr` < 32, `memWrData` is stored into register `memAddr`. For an address of 32 or above the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rdAddrA | input | 5 | Byte read port A index |
| rdDataA | output | 8 | Byte read port A data |
| rdAddrB | input | 5 | Byte read port B index |
| rdDataB | output | 8 | Byte read port B data |
| pairRdAddr | input | 5 | Pair read base index (even) |
| pairRdData | output | 16 | Pair read word |
| pairRdErr | output | 1 | Pair read base is odd |
| wrEn | input | 1 | General write enable |
| wrWide | input | 1 | General write is a 16-bit pair |
| wrAddr | input | 5 | General write index |
| wrData | input | 16 | General write data (byte writes use bits 7:0) |
| wrErr | output | 1 | Pair write with odd base, ignored |
| ptrWrEn | input | 1 | Pointer load enable |
| ptrSel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| ptrWrData | input | 16 | Pointer load word |
| ptrWords | output | 48 | X, Y, Z words, X in bits 15:0 |
| memAddr | input | 16 | Data-space byte address |
| memWrEn | input | 1 | Data-space byte write enable |
| memWrData | input | 8 | Data-space write byte |
| memRdData | output | 8 | Data-space read byte |
| memHit | output | 1 | Address falls in the register window |

## Verification
The assertions for byte and pair writes assume that the general write port always wins. Those for pointer loads only fire when no general or data-bus write is active in the same cycle, so they do not rely on the stimulus avoiding collisions. The odd-base check likewise requires the pointer and data-bus ports to be idle, and the bench keeps them idle in every odd-base cycle it drives. Deliberate collisions appear only in the priority scenario, where the expected bytes are worked out per byte. Every other cycle drives one source at a time, so the bench's model of the 32 bytes stays exact.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int GPR_COUNT = 32;
  localparam int GPR_W = 8;
  localparam int GPR_AW = $clog2(GPR_COUNT);

  typedef enum logic [1:0] {
    SRC_GEN_BYTE = 2'd0,
    SRC_GEN_PAIR = 2'd1,
    SRC_MEM      = 2'd2,
    SRC_PTR      = 2'd3
  } gpr_src_e;

  typedef struct packed {
    logic [GPR_COUNT-1:0]     en;
    gpr_src_e [GPR_COUNT-1:0] src;
    logic                     memHit;
  } gpr_strobe_t;
endpackage

// File: rtl/gpr_ctrl.sv
module gpr_ctrl
  import gpr_pkg::*;
#(
  parameter int NUM_PTRS = 3,
  parameter int PTR_BASE = 26,
  parameter int MEM_AW = 16,
  parameter int PSEL_W = 2
) (
  input  logic              wrEn,
  input  logic              wrWide,
  input  logic [GPR_AW-1:0] wrAddr,
  input  logic              ptrWrEn,
  input  logic [PSEL_W-1:0] ptrSel,
  input  logic [MEM_AW-1:0] memAddr,
  input  logic              memWrEn,
  input  logic [GPR_AW-1:0] pairRdAddr,
  output gpr_strobe_t       stb,
  output logic              wrErr,
  output logic              pairRdErr
);
  localparam int PTR_PAIR0 = PTR_BASE / 2;

  logic memHit;
  assign memHit = (memAddr < MEM_AW'(GPR_COUNT));
  assign wrErr = wrEn & wrWide & wrAddr[0];
  assign pairRdErr = pairRdAddr[0];

  always_comb begin
    stb.memHit = memHit;
    for (int r = 0; r < GPR_COUNT; r++) begin
      // lowest priority first; later matches override
      stb.en[r] = 1'b0;
      stb.src[r] = SRC_GEN_BYTE;
      for (int j = 0; j < NUM_PTRS; j++) begin
        if (ptrWrEn && int'(ptrSel) == j && (r / 2) == PTR_PAIR0 + j) begin
          stb.en[r] = 1'b1;
          stb.src[r] = SRC_PTR;
        end
      end
      if (memWrEn && memHit && int'(memAddr[GPR_AW-1:0]) == r) begin
        stb.en[r] = 1'b1;
        stb.src[r] = SRC_MEM;
      end
      if (wrEn && !wrWide && int'(wrAddr) == r) begin
        stb.en[r] = 1'b1;
        stb.src[r] = SRC_GEN_BYTE;
      end
      if (wrEn && wrWide && !wrAddr[0] && int'(wrAddr[GPR_AW-1:1]) == (r / 2)) begin
        stb.en[r] = 1'b1;
        stb.src[r] = SRC_GEN_PAIR;
      end
    end
  end
endmodule

// File: rtl/gpr_dp.sv
module gpr_dp
  import gpr_pkg::*;
#(
  parameter int NUM_PTRS = 3,
  parameter int PTR_BASE = 26,
  parameter int MEM_AW = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  gpr_strobe_t              stb,
  input  logic [2*GPR_W-1:0]       wrData,
  input  logic [GPR_W-1:0]         memWrData,
  input  logic [2*GPR_W-1:0]       ptrWrData,
  input  logic [GPR_AW-1:0]        rdAddrA,
  input  logic [GPR_AW-1:0]        rdAddrB,
  input  logic [GPR_AW-1:0]        pairRdAddr,
  input  logic [MEM_AW-1:0]        memAddr,
  output logic [GPR_W-1:0]         rdDataA,
  output logic [GPR_W-1:0]         rdDataB,
  output logic [2*GPR_W-1:0]       pairRdData,
  output logic [GPR_W-1:0]         memRdData,
  output logic [NUM_PTRS*2*GPR_W-1:0] ptrWords,
  output logic [GPR_COUNT*GPR_W-1:0]  regView
);
  logic [GPR_W-1:0] regs [GPR_COUNT];

  for (genvar r = 0; r < GPR_COUNT; r++) begin : g_reg
    logic [GPR_W-1:0] nextByte;
    always_comb begin
      case (stb.src[r])
        SRC_GEN_BYTE: nextByte = wrData[GPR_W-1:0];
        SRC_GEN_PAIR: nextByte = (r % 2 == 1) ? wrData[2*GPR_W-1:GPR_W] : wrData[GPR_W-1:0];
        SRC_MEM:      nextByte = memWrData;
        default:      nextByte = (r % 2 == 1) ? ptrWrData[2*GPR_W-1:GPR_W] : ptrWrData[GPR_W-1:0];
      endcase
    end
    always_ff @(posedge clk) begin
      if (rst) regs[r] <= '0;
      else if (stb.en[r]) regs[r] <= nextByte;
    end
    assign regView[r*GPR_W +: GPR_W] = regs[r];
  end

  for (genvar j = 0; j < NUM_PTRS; j++) begin : g_ptr
    assign ptrWords[j*2*GPR_W +: 2*GPR_W] = {regs[PTR_BASE + 2*j + 1], regs[PTR_BASE + 2*j]};
  end

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];
  assign pairRdData = pairRdAddr[0] ? '0 :
                      {regs[{pairRdAddr[GPR_AW-1:1], 1'b1}], regs[{pairRdAddr[GPR_AW-1:1], 1'b0}]};
  assign memRdData = stb.memHit ? regs[memAddr[GPR_AW-1:0]] : '0;
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int NUM_PTRS = 3,
  parameter int PTR_BASE = 26,
  parameter int MEM_AW = 16,
  localparam int PSEL_W = (NUM_PTRS > 1) ? $clog2(NUM_PTRS + 1) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [GPR_AW-1:0]           rdAddrA,
  output logic [GPR_W-1:0]            rdDataA,
  input  logic [GPR_AW-1:0]           rdAddrB,
  output logic [GPR_W-1:0]            rdDataB,
  input  logic [GPR_AW-1:0]           pairRdAddr,
  output logic [2*GPR_W-1:0]          pairRdData,
  output logic                        pairRdErr,
  input  logic                        wrEn,
  input  logic                        wrWide,
  input  logic [GPR_AW-1:0]           wrAddr,
  input  logic [2*GPR_W-1:0]          wrData,
  output logic                        wrErr,
  input  logic                        ptrWrEn,
  input  logic [PSEL_W-1:0]           ptrSel,
  input  logic [2*GPR_W-1:0]          ptrWrData,
  output logic [NUM_PTRS*2*GPR_W-1:0] ptrWords,
  input  logic [MEM_AW-1:0]           memAddr,
  input  logic                        memWrEn,
  input  logic [GPR_W-1:0]            memWrData,
  output logic [GPR_W-1:0]            memRdData,
  output logic                        memHit
);
  gpr_strobe_t stb;
  logic [GPR_COUNT*GPR_W-1:0] regView;

  gpr_ctrl #(.NUM_PTRS(NUM_PTRS), .PTR_BASE(PTR_BASE), .MEM_AW(MEM_AW), .PSEL_W(PSEL_W)) u_ctrl (
    .wrEn(wrEn), .wrWide(wrWide), .wrAddr(wrAddr), .ptrWrEn(ptrWrEn), .ptrSel(ptrSel),
    .memAddr(memAddr), .memWrEn(memWrEn), .pairRdAddr(pairRdAddr),
    .stb(stb), .wrErr(wrErr), .pairRdErr(pairRdErr)
  );

  gpr_dp #(.NUM_PTRS(NUM_PTRS), .PTR_BASE(PTR_BASE), .MEM_AW(MEM_AW)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData), .memWrData(memWrData),
    .ptrWrData(ptrWrData), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .pairRdAddr(pairRdAddr),
    .memAddr(memAddr), .rdDataA(rdDataA), .rdDataB(rdDataB), .pairRdData(pairRdData),
    .memRdData(memRdData), .ptrWords(ptrWords), .regView(regView)
  );

  assign memHit = stb.memHit;
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk
  import gpr_pkg::*;
#(
  parameter int NUM_PTRS = 3,
  parameter int MEM_AW = 16,
  parameter int PSEL_W = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        wrEn,
  input logic                        wrWide,
  input logic [GPR_AW-1:0]           wrAddr,
  input logic [2*GPR_W-1:0]          wrData,
  input logic                        wrErr,
  input logic                        ptrWrEn,
  input logic [PSEL_W-1:0]           ptrSel,
  input logic [2*GPR_W-1:0]          ptrWrData,
  input logic [NUM_PTRS*2*GPR_W-1:0] ptrWords,
  input logic                        memWrEn,
  input logic [MEM_AW-1:0]           memAddr,
  input logic [GPR_W-1:0]            memRdData,
  input logic                        memHit,
  input logic [GPR_AW-1:0]           pairRdAddr,
  input logic [2*GPR_W-1:0]          pairRdData,
  input logic [GPR_COUNT*GPR_W-1:0]  regView
);
  // R2
  byte_write_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn && !wrWide |=> regView[int'($past(wrAddr))*GPR_W +: GPR_W] == $past(wrData[GPR_W-1:0]));

  // R4
  pair_write_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn && wrWide && !wrAddr[0] |=> regView[int'($past(wrAddr))*GPR_W +: 2*GPR_W] == $past(wrData));

  // R5
  odd_flag_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn && wrWide && wrAddr[0] |-> wrErr);

  // R5
  odd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn && wrWide && wrAddr[0] && !ptrWrEn && !memWrEn |=> $stable(regView));

  // R6
  pair_read_chk: assert property (@(posedge clk) disable iff (rst)
    !pairRdAddr[0] |-> pairRdData == regView[int'(pairRdAddr)*GPR_W +: 2*GPR_W]);

  // R9
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    ptrWrEn && int'(ptrSel) < NUM_PTRS && !wrEn && !memWrEn
    |=> ptrWords[int'($past(ptrSel))*2*GPR_W +: 2*GPR_W] == $past(ptrWrData));

  // R11
  mem_view_chk: assert property (@(posedge clk) disable iff (rst)
    memHit |-> memRdData == regView[int'(memAddr[GPR_AW-1:0])*GPR_W +: GPR_W]);
endmodule

bind gpr_file gpr_file_chk #(.NUM_PTRS(NUM_PTRS), .MEM_AW(MEM_AW), .PSEL_W(PSEL_W)) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrWide(wrWide), .wrAddr(wrAddr), .wrData(wrData),
  .wrErr(wrErr), .ptrWrEn(ptrWrEn), .ptrSel(ptrSel), .ptrWrData(ptrWrData), .ptrWords(ptrWords),
  .memWrEn(memWrEn), .memAddr(memAddr), .memRdData(memRdData), .memHit(memHit),
  .pairRdAddr(pairRdAddr), .pairRdData(pairRdData), .regView(regView)
);

// File: tb/gpr_file_tb.sv
module gpr_file_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic [4:0] rdAddrA, rdAddrB, pairRdAddr, wrAddr;
  logic [7:0] rdDataA, rdDataB, memRdData, memWrData;
  logic [15:0] pairRdData, wrData, ptrWrData, memAddr;
  logic pairRdErr, wrEn, wrWide, wrErr, ptrWrEn, memWrEn, memHit;
  logic [1:0] ptrSel;
  logic [47:0] ptrWords;

  logic [7:0] mdl [32];
  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpr_file u_dut (
    .clk(clk), .rst(rst), .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .pairRdAddr(pairRdAddr), .pairRdData(pairRdData), .pairRdErr(pairRdErr),
    .wrEn(wrEn), .wrWide(wrWide), .wrAddr(wrAddr), .wrData(wrData), .wrErr(wrErr),
    .ptrWrEn(ptrWrEn), .ptrSel(ptrSel), .ptrWrData(ptrWrData), .ptrWords(ptrWords),
    .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData), .memRdData(memRdData), .memHit(memHit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; wrWide = 0; ptrWrEn = 0; memWrEn = 0;
    wrAddr = 0; wrData = 0; ptrSel = 0; ptrWrData = 0; memWrData = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic checkAll(input string req);
    for (int r = 0; r < 32; r++) begin
      memAddr = 16'(r);
      #1;
      check(req, {24'd0, memRdData}, {24'd0, mdl[r]});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    idle();
    rdAddrA = 0; rdAddrB = 0; pairRdAddr = 0; memAddr = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int r = 0; r < 32; r++) mdl[r] = 8'h00;
    // R1: state after the first reset
    checkAll("R1");

    // R2/R3: byte write sweep, read on both ports
    for (int r = 0; r < 32; r++) begin
      wrEn = 1; wrAddr = 5'(r); wrData = 16'((r * 37 + 11) & 255);
      mdl[r] = 8'((r * 37 + 11) & 255);
      step();
    end
    for (int r = 0; r < 32; r++) begin
      rdAddrA = 5'(r); rdAddrB = 5'(31 - r);
      #1;
      check("R2/R3 portA", {24'd0, rdDataA}, {24'd0, mdl[r]});
      check("R3 portB", {24'd0, rdDataB}, {24'd0, mdl[31 - r]});
    end

    // R11: window and outside addresses
    checkAll("R11");
    for (int a = 0; a < 32; a++) begin
      memAddr = 16'(a); #1;
      check("R11 hit", {31'd0, memHit}, 32'd1);
    end
    memAddr = 16'd32; #1;
    check("R11 miss32", {23'd0, memHit, memRdData}, 32'd0);
    memAddr = 16'h0105; #1;
    check("R11 miss105", {23'd0, memHit, memRdData}, 32'd0);
    memAddr = 16'hFFFF; #1;
    check("R11 missFFFF", {23'd0, memHit, memRdData}, 32'd0);

    // R4/R6: pair write every even base, pair read back
    for (int k = 0; k < 16; k++) begin
      wrEn = 1; wrWide = 1; wrAddr = 5'(2 * k); wrData = 16'((k * 16'h1357) ^ 16'hA5C3);
      mdl[2*k] = wrData[7:0]; mdl[2*k+1] = wrData[15:8];
      #1;
      check("R4 no err", {31'd0, wrErr}, 32'd0);
      step();
    end
    for (int k = 0; k < 16; k++) begin
      pairRdAddr = 5'(2 * k); #1;
      check("R4/R6 pair", {15'd0, pairRdErr, pairRdData}, {16'd0, mdl[2*k+1], mdl[2*k]});
    end
    for (int k = 0; k < 16; k++) begin
      pairRdAddr = 5'(2 * k + 1); #1;
      check("R6 odd", {15'd0, pairRdErr, pairRdData}, 32'h10000);
    end
    checkAll("R4");

    // R5: odd base pair write is flagged and ignored
    for (int k = 0; k < 16; k++) begin
      wrEn = 1; wrWide = 1; wrAddr = 5'(2 * k + 1); wrData = 16'hDEAD;
      #1;
      check("R5 flag", {31'd0, wrErr}, 32'd1);
      step();
    end
    checkAll("R5");

    // R8: pointer words follow the top registers
    for (int j = 0; j < 3; j++)
      check("R8", {16'd0, ptrWords[16*j +: 16]}, {16'd0, mdl[27+2*j], mdl[26+2*j]});

    // R9: pointer loads, then an invalid select
    for (int j = 0; j < 3; j++) begin
      ptrWrEn = 1; ptrSel = 2'(j); ptrWrData = 16'(16'h1111 * (j + 1) + 16'h0F0E);
      mdl[26+2*j] = ptrWrData[7:0]; mdl[27+2*j] = ptrWrData[15:8];
      step();
      check("R9", {16'd0, ptrWords[16*j +: 16]}, {16'd0, mdl[27+2*j], mdl[26+2*j]});
    end
    ptrWrEn = 1; ptrSel = 2'd3; ptrWrData = 16'hBEEF;
    step();
    checkAll("R9 sel3");

    // R10: general byte beats pointer on the low byte of X
    wrEn = 1; wrAddr = 5'd26; wrData = 16'h0077;
    ptrWrEn = 1; ptrSel = 2'd0; ptrWrData = 16'hABCD;
    mdl[26] = 8'h77; mdl[27] = 8'hAB;
    step();
    check("R10 gen>ptr", {16'd0, ptrWords[15:0]}, 32'hAB77);
    // R10: data bus beats pointer on the high byte of Y
    memWrEn = 1; memAddr = 16'd29; memWrData = 8'h5A;
    ptrWrEn = 1; ptrSel = 2'd1; ptrWrData = 16'h1234;
    mdl[28] = 8'h34; mdl[29] = 8'h5A;
    step();
    check("R10 mem>ptr", {16'd0, ptrWords[31:16]}, 32'h5A34);
    // R10: general pair beats data bus
    wrEn = 1; wrWide = 1; wrAddr = 5'd30; wrData = 16'hC3C2;
    memWrEn = 1; memAddr = 16'd31; memWrData = 8'h99;
    mdl[30] = 8'hC2; mdl[31] = 8'hC3;
    step();
    check("R10 gen>mem", {16'd0, ptrWords[47:32]}, 32'hC3C2);
    checkAll("R10");

    // R7: read during write returns old value
    rdAddrA = 5'd9; pairRdAddr = 5'd8;
    wrEn = 1; wrAddr = 5'd9; wrData = 16'h00E1;
    #1;
    check("R7 old", {24'd0, rdDataA}, {24'd0, mdl[9]});
    check("R7 old pair", {16'd0, pairRdData}, {16'd0, mdl[9], mdl[8]});
    mdl[9] = 8'hE1;
    step();
    #1;
    check("R7 new", {24'd0, rdDataA}, 32'hE1);

    // R12: data-bus writes inside and outside the window
    for (int r = 0; r < 32; r += 5) begin
      memWrEn = 1; memAddr = 16'(r); memWrData = 8'(255 - r);
      mdl[r] = 8'(255 - r);
      step();
    end
    memWrEn = 1; memAddr = 16'h0040; memWrData = 8'h66;
    step();
    memWrEn = 1; memAddr = 16'h0021; memWrData = 8'h66;
    step();
    checkAll("R12");

    // R1: reset after activity
    rst = 1;
    @(negedge clk);
    rst = 0;
    for (int r = 0; r < 32; r++) mdl[r] = 8'h00;
    checkAll("R1 again");
    check("R1 ptr", {16'd0, ptrWords[15:0]}, 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule